// File: doc/BRIEF.md
# Bitmap Pixel Serializer with DAC Level Encoder

This block turns a byte-packed monochrome bitmap into a serial pixel stream for a composite video output. A separate timing generator tells it, cycle by cycle, whether the raster is in the active picture, a border, a blanking interval or a sync pulse. During the active picture the block reads one byte from a video memory for every eight pixel clocks. It shifts the byte out with the most significant bit first, and the next byte arrives just in time to follow the last bit of the current one.

Each cycle the block folds the timing state and the current pixel into one of four analog levels: sync, blank, black or white. It drives them as a three-line active-low word for a resistor-ladder DAC. No more than one line is ever pulled low. All three lines come from one register, so a change from one level to another never shows a passing white level.

The read address restarts at zero on each frame pulse. It wraps at the size of the video memory, so a memory smaller than a frame repeats its image down the screen. Every DAC output trails the timing requests by exactly two clock cycles, and the timing generator advances its requests by that amount.

Top module: `bitmap_pix_serializer`

## Requirements
- R1: The memory address is zero while reset is held, and zero in the cycle after any cycle in which `frame_start` is high.
- R2: The address advances by exactly one in the cycle after each active cycle that begins a byte, and holds otherwise. A byte begins on the first cycle of each unbroken run of `req_active` and on every eighth active cycle after it. A full visible line of 256 active cycles therefore advances the address by 32.
- R3: The address counts modulo MEM_BYTES, whether or not MEM_BYTES is a power of two. After MEM_BYTES-1 it returns to 0.
- R4: Within a run of active cycles, active cycle k shows bit 7-(k mod 8) of the byte stored at the address presented on the byte's first cycle. Bit 7 is shown first, and a new byte follows the previous one with no gap.
- R5: In an active cycle with no higher-priority request, pixel 1 gives white (all three lines high) and pixel 0 gives black (only `dac_pix_n` low).
- R6: `req_border` gives black whatever the pixel data, and overrides `req_active`. The address still advances for active cycles that are hidden this way.
- R7: `req_sync` gives the sync level (only `dac_sync_n` low) and overrides every other request.
- R8: `req_blank` without `req_sync` gives the blank level (only `dac_blank_n` low), and overrides border and active.
- R9: A cycle with no request gives the blank level.
- R10: At most one of `dac_sync_n`, `dac_pix_n` and `dac_blank_n` is low in any cycle.
- R11: The DAC lines show the level for the requests sampled two clock edges earlier. All three lines change on the same edge.
- R12: While reset is held, the DAC word is at the blank level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse that restarts the scan address at zero |
| req_active | input | 1 | Timing generator: active picture pixel |
| req_border | input | 1 | Timing generator: border, forces black |
| req_blank | input | 1 | Timing generator: blanking interval |
| req_sync | input | 1 | Timing generator: sync pulse |
| mem_addr | output | ADDR_W (10) | Byte address to the video memory, registered |
| mem_rdata | input | BYTE_W (8) | Byte read from the memory, valid one cycle after the address |
| dac_sync_n | output | 1 | Active-low DAC line for the sync level |
| dac_pix_n | output | 1 | Active-low DAC line for the black level |
| dac_blank_n | output | 1 | Active-low DAC line for the blank level |

## Verification
The bench builds two copies with 64-pixel lines. One has a 44-byte memory, which selects the compare-and-clear wrap and makes the wrap fall in the middle of a line. The other has a 32-byte memory, which selects the natural binary wrap. Full frames of 12 lines go through both wrap variants many times. An exhaustive sweep of all 32 combinations of the five request inputs, repeated three times, exercises every priority case. The sweep also covers partial active runs, frame pulses during active cycles, and borders that hide active pixels.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

   typedef enum logic [1:0] {
      LVL_SYNC  = 2'd0,
      LVL_BLANK = 2'd1,
      LVL_BLACK = 2'd2,
      LVL_WHITE = 2'd3
   } level_e;

   // Active-low ladder drive: at most one field may be zero
   typedef struct packed {
      logic blank_n;
      logic pix_n;
      logic sync_n;
   } ladder_t;

   localparam ladder_t LADDER_BLANK = '{blank_n: 1'b0, pix_n: 1'b1, sync_n: 1'b1};

   function automatic ladder_t level_to_ladder(level_e lvl);
      ladder_t w;
      w = '{blank_n: 1'b1, pix_n: 1'b1, sync_n: 1'b1};
      unique case (lvl)
         LVL_SYNC:  w.sync_n  = 1'b0;
         LVL_BLANK: w.blank_n = 1'b0;
         LVL_BLACK: w.pix_n   = 1'b0;
         default:   ;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/pxs_addr_gen.sv
module pxs_addr_gen #(
   parameter int MEM_BYTES = 1024,
   parameter int BYTE_W    = 8,
   parameter int LINE_PIX  = 256,
   parameter int ADDR_W    = $clog2(MEM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              active,
   output logic [ADDR_W-1:0] addr_q,
   output logic              act_q,
   output logic              load_q
);

   localparam int BIT_W  = $clog2(BYTE_W);
   localparam int RUN_W  = $clog2(LINE_PIX + 1);
   localparam bit POW2   = (MEM_BYTES & (MEM_BYTES - 1)) == 0;

   logic [BIT_W-1:0]  bit_cnt;
   logic [RUN_W-1:0]  run_cnt;
   logic [ADDR_W-1:0] addr_inc;
   logic              byte_begin;

   assign byte_begin = active && (bit_cnt == '0);

   generate
      if (POW2) begin : g_wrap_bin
         assign addr_inc = addr_q + ADDR_W'(1);
      end else begin : g_wrap_cmp
         assign addr_inc = (addr_q == ADDR_W'(MEM_BYTES - 1)) ? '0 : addr_q + ADDR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         bit_cnt <= '0;
         run_cnt <= '0;
         act_q   <= 1'b0;
         load_q  <= 1'b0;
      end else begin
         act_q  <= active;
         load_q <= byte_begin;
         if (frame_start)     addr_q <= '0;
         else if (byte_begin) addr_q <= addr_inc;
         if (frame_start)     bit_cnt <= '0;
         else if (active)     bit_cnt <= bit_cnt + BIT_W'(1);
         else                 bit_cnt <= '0;
         if (!active)         run_cnt <= '0;
         else if (32'(run_cnt) < LINE_PIX) run_cnt <= run_cnt + RUN_W'(1);
      end
   end

   assert_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (addr_q == '0));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_begin && !frame_start) |=>
         (32'(addr_q) == (32'($past(addr_q)) + 1) % MEM_BYTES));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_begin && !frame_start) |=> $stable(addr_q));

   assert_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (32'(run_cnt) < LINE_PIX));

   assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(addr_q) < MEM_BYTES);

endmodule

// File: rtl/pxs_shifter.sv
module pxs_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_i,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] rdata_i,
   output logic              pix_o
);

   logic [BYTE_W-1:0] shift_q;

   // The fetched byte feeds the pixel directly on its first cycle; the rest are held here
   assign pix_o = load_i ? rdata_i[BYTE_W-1] : shift_q[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shift_q <= '0;
      else if (load_i) shift_q <= rdata_i << 1;
      else if (act_i)  shift_q <= shift_q << 1;
   end

   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> act_i);

endmodule

// File: rtl/pxs_level_enc.sv
module pxs_level_enc
   import pxs_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    sync_i,
   input  logic    blank_i,
   input  logic    border_i,
   input  logic    act_q,
   input  logic    pix_i,
   output ladder_t drive_q
);

   logic   sync_d, blank_d, border_d;
   level_e lvl;

   always_comb begin
      if (sync_d)        lvl = LVL_SYNC;
      else if (blank_d)  lvl = LVL_BLANK;
      else if (border_d) lvl = LVL_BLACK;
      else if (act_q)    lvl = pix_i ? LVL_WHITE : LVL_BLACK;
      else               lvl = LVL_BLANK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_d   <= 1'b0;
         blank_d  <= 1'b0;
         border_d <= 1'b0;
         drive_q  <= LADDER_BLANK;
      end else begin
         sync_d   <= sync_i;
         blank_d  <= blank_i;
         border_d <= border_i;
         drive_q  <= level_to_ladder(lvl);
      end
   end

   assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~drive_q) <= 1);

   assert_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_d |=> (!drive_q.sync_n && drive_q.pix_n && drive_q.blank_n));

   assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_d && !sync_d) |=> (!drive_q.blank_n && drive_q.pix_n));

   assert_border_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (border_d && !blank_d && !sync_d) |=> !drive_q.pix_n);

endmodule

// File: rtl/bitmap_pix_serializer.sv
module bitmap_pix_serializer
   import pxs_pkg::*;
#(
   parameter int LINE_PIX  = 256,
   parameter int BYTE_W    = 8,
   parameter int MEM_BYTES = 1024,
   parameter int ADDR_W    = $clog2(MEM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              req_active,
   input  logic              req_border,
   input  logic              req_blank,
   input  logic              req_sync,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              dac_sync_n,
   output logic              dac_pix_n,
   output logic              dac_blank_n
);

   localparam int BYTES_PER_LINE = LINE_PIX / BYTE_W;

   generate
      if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_chk_byte
         $error("BYTE_W must be a power of two of at least 2");
      end
      if (LINE_PIX % BYTE_W != 0 || BYTES_PER_LINE < 1) begin : g_chk_line
         $error("LINE_PIX must be a nonzero multiple of BYTE_W");
      end
      if (MEM_BYTES < 2) begin : g_chk_mem
         $error("MEM_BYTES must be at least 2");
      end
      if (ADDR_W != $clog2(MEM_BYTES)) begin : g_chk_addr
         $error("ADDR_W must equal clog2(MEM_BYTES)");
      end
   endgenerate

   logic    act_q, load_q, pix;
   ladder_t drive_q;

   pxs_addr_gen #(
      .MEM_BYTES (MEM_BYTES),
      .BYTE_W    (BYTE_W),
      .LINE_PIX  (LINE_PIX),
      .ADDR_W    (ADDR_W)
   ) u_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .active      (req_active),
      .addr_q      (mem_addr),
      .act_q       (act_q),
      .load_q      (load_q)
   );

   pxs_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_i   (act_q),
      .load_i  (load_q),
      .rdata_i (mem_rdata),
      .pix_o   (pix)
   );

   pxs_level_enc u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (req_sync),
      .blank_i  (req_blank),
      .border_i (req_border),
      .act_q    (act_q),
      .pix_i    (pix),
      .drive_q  (drive_q)
   );

   assign dac_sync_n  = drive_q.sync_n;
   assign dac_pix_n   = drive_q.pix_n;
   assign dac_blank_n = drive_q.blank_n;

endmodule

// File: tb/sim_bitmap_pix_serializer.sv
module sim_bitmap_pix_serializer;

   localparam int LP = 64;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, fs, ra, rb, rk, rs;
   logic [5:0] a0;
   logic [4:0] a1;
   logic [7:0] m0, m1;
   logic s0, p0, k0, s1, p1, k1;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   bitmap_pix_serializer #(.LINE_PIX(LP), .BYTE_W(8), .MEM_BYTES(44), .ADDR_W(6)) u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(fs), .req_active(ra), .req_border(rb),
      .req_blank(rk), .req_sync(rs), .mem_addr(a0), .mem_rdata(m0),
      .dac_sync_n(s0), .dac_pix_n(p0), .dac_blank_n(k0));

   bitmap_pix_serializer #(.LINE_PIX(LP), .BYTE_W(8), .MEM_BYTES(32), .ADDR_W(5)) u1 (
      .clk(clk), .rst_n(rst_n), .frame_start(fs), .req_active(ra), .req_border(rb),
      .req_blank(rk), .req_sync(rs), .mem_addr(a1), .mem_rdata(m1),
      .dac_sync_n(s1), .dac_pix_n(p1), .dac_blank_n(k1));

   function automatic logic [7:0] memf(int a);
      logic [7:0] x;
      x = 8'(a * 29 + 90);
      return x ^ {x[3:0], x[7:4]};
   endfunction

   // Memory models: one cycle read latency
   always @(posedge clk) begin
      m0 <= memf(int'(a0));
      m1 <= memf(int'(a1));
   end

   function automatic int msize(int d);
      return (d == 0) ? 44 : 32;
   endfunction

   function automatic logic [2:0] drv(int d);
      return (d == 0) ? {k0, p0, s0} : {k1, p1, s1};
   endfunction

   function automatic int addr_of(int d);
      return (d == 0) ? int'(a0) : int'(a1);
   endfunction

   // Encodings {blank_n, pix_n, sync_n}
   localparam logic [2:0] L_SYNC = 3'b110, L_BLANK = 3'b011, L_BLACK = 3'b101, L_WHITE = 3'b111;

   int         e_addr [2];
   int         bitc   [2];
   logic [7:0] cbyte  [2];
   logic [2:0] exa    [2];
   logic [2:0] exb    [2];
   string      taga, tagb;
   string      atag   [2];

   task automatic chk(string tag, int d, int act, int exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s dut%0d: actual %0h expected %0h", tag, d, act, exp);
      end
   endtask

   task automatic step(input logic a, input logic bo, input logic bl, input logic sy, input logic f);
      string nt;
      @(negedge clk);
      for (int d = 0; d < 2; d++) begin
         chk({tagb, " R11"}, d, int'(drv(d)), int'(exb[d]));
         chk("R10", d, int'($countones(~drv(d)) <= 1), 1);
         chk(atag[d], d, addr_of(d), e_addr[d]);
      end
      if (sy)      nt = "R7";
      else if (bl) nt = "R8";
      else if (bo) nt = "R6";
      else if (a)  nt = "R4 R5";
      else         nt = "R9";
      tagb = taga;
      taga = nt;
      for (int d = 0; d < 2; d++) begin
         logic pixv;
         exb[d] = exa[d];
         if (a && bitc[d] == 0) cbyte[d] = memf(e_addr[d]);
         pixv = cbyte[d][7 - bitc[d]];
         if (sy)      exa[d] = L_SYNC;
         else if (bl) exa[d] = L_BLANK;
         else if (bo) exa[d] = L_BLACK;
         else if (a)  exa[d] = pixv ? L_WHITE : L_BLACK;
         else         exa[d] = L_BLANK;
         if (f) begin
            atag[d] = "R1";
            if (a && bitc[d] == 0) atag[d] = "R1";
            e_addr[d] = 0;
         end else if (a && bitc[d] == 0) begin
            atag[d] = (e_addr[d] + 1 == msize(d)) ? "R3" : "R2";
            e_addr[d] = (e_addr[d] + 1) % msize(d);
         end else begin
            atag[d] = "R2";
         end
         bitc[d] = f ? 0 : (a ? (bitc[d] + 1) % 8 : 0);
      end
      ra = a; rb = bo; rk = bl; rs = sy; fs = f;
   endtask

   task automatic line(input logic hide);
      repeat (2) step(0, 0, 1, 0, 0);
      repeat (4) step(0, 0, 0, 1, 0);
      repeat (2) step(0, 0, 1, 0, 0);
      repeat (3) step(0, 1, 0, 0, 0);
      for (int i = 0; i < LP; i++) step(1, hide, 0, 0, 0);
      repeat (2) step(0, 1, 0, 0, 0);
      step(0, 0, 0, 0, 0);
   endtask

   initial begin
      rst_n = 0; fs = 0; ra = 0; rb = 0; rk = 0; rs = 0;
      taga = "R12"; tagb = "R12";
      for (int d = 0; d < 2; d++) begin
         e_addr[d] = 0; bitc[d] = 0; cbyte[d] = '0;
         exa[d] = L_BLANK; exb[d] = L_BLANK; atag[d] = "R1";
      end
      repeat (3) begin
         @(negedge clk);
         for (int d = 0; d < 2; d++) begin
            chk("R12", d, int'(drv(d)), int'(L_BLANK));
            chk("R1", d, addr_of(d), 0);
         end
      end
      @(negedge clk);
      rst_n = 1;
      for (int f = 0; f < 3; f++) begin
         step(0, 0, 1, 0, 1);
         for (int l = 0; l < 12; l++) line(f == 2 && l == 3);
      end
      for (int rep = 0; rep < 3; rep++)
         for (int c = 0; c < 32; c++)
            step(c[0], c[1], c[2], c[3], c[4]);
      repeat (3) step(0, 0, 0, 0, 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule